// File: doc/BRIEF.md
# Fast GPIO Port with Atomic Bit Toggle

This block is a 16-bit general-purpose I/O port that sits on a processor's local two-stage pipelined bus. The processor sets up each pin through memory-mapped registers. One register enables the pin, one picks its direction, and one holds its output value. A separate write-only toggle register flips any chosen set of output bits in a single write, with no read-modify-write sequence. Every access finishes with zero wait states. The bus presents the address and the read/write qualifier in one cycle, and the data moves in the cycle after that.

Pin drive is split into an output value and an output enable per pin, so the pad ring can build the tri-state buffer. A pin is driven only when it is enabled and set as an output. For an enabled input pin, reading the data register returns the pin level after a two-flop synchroniser. For every other pin it returns the latched output bit. Each access is 16 bits wide and address bit 0 is ignored.

Top module: `fgpio_port`

## Requirements
- R1: After reset is released, the enable, direction and data registers are all zero. Every pin_oe bit is 0, every pin_out bit is 0, and a read of any offset returns 0.
- R2: A write to offset 0x0 (direction, 1 = output) or offset 0x4 (enable, 1 = enabled) stores all 16 bits of the write data. A read of the same offset returns the stored value.
- R3: pin_oe[i] is 1 exactly when enable bit i and direction bit i are both 1. pin_out[i] equals data bit i while pin_oe[i] is 1, and is 0 otherwise.
- R4: A write to offset 0xE inverts every data-register bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R5: A read of offset 0xE returns all zeros.
- R6: A write to any offset other than 0x0, 0x2, 0x4 and 0xE changes no register and no pin output. A read of such an offset returns 0.
- R7: A read of offset 0x2 returns, for each bit, the synchronised pin level when that pin is enabled with direction 0. For all other pins it returns the stored data bit.
- R8: A change on pin_in reaches the read value of offset 0x2 after exactly two rising clock edges.
- R9: A write takes effect on the clock edge that ends its data cycle. Read data is valid during the data cycle that directly follows the address cycle, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_vld | input | 1 | Address cycle carries an access |
| a_wr | input | 1 | Access is a write (1) or read (0) |
| a_adr | input | 4 | Byte offset of the access |
| d_wdata | input | 16 | Write data, valid in the data cycle |
| d_rdata | output | 16 | Read data, valid in the data cycle |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Value to drive on each pin |
| pin_oe | output | 16 | Drive enable per pin |

## Verification
A wrong stored bit in the enable, direction or data register shows on pin_oe or pin_out right after the edge that wrote it. If it is masked there because the pin is undriven, it shows at the latest on the next read of that offset, one cycle after the address is issued. A toggle that hits the wrong bits, or a stray write to an undefined offset, changes the pin outputs on the edge that ends its data cycle. A synchroniser of the wrong depth shows as a read value of offset 0x2 that changes one edge early or late after a pin change.

// File: rtl/fgpio_port.sv
module fgpio_port #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic          a_wr,
  input  logic [AW-1:0] a_adr,
  input  logic [W-1:0]  d_wdata,
  output logic [W-1:0]  d_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  localparam logic [AW-2:0] SEL_DIR = 3'd0;
  localparam logic [AW-2:0] SEL_DAT = 3'd1;
  localparam logic [AW-2:0] SEL_ENB = 3'd2;
  localparam logic [AW-2:0] SEL_TOG = 3'd7;

  logic          dp_vld, dp_wr;
  logic [AW-2:0] dp_sel;
  logic [W-1:0]  dir_q, dat_q, enb_q, s1_q, s2_q, dat_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dp_vld <= 1'b0;
      dp_wr  <= 1'b0;
      dp_sel <= '0;
    end else begin
      dp_vld <= a_vld;
      dp_wr  <= a_wr;
      dp_sel <= a_adr[AW-1:1];
    end

  wire we = dp_vld & dp_wr;
  wire rd = dp_vld & ~dp_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      enb_q <= '0;
      dat_q <= '0;
    end else if (we) begin
      if (dp_sel == SEL_DIR) dir_q <= d_wdata;
      if (dp_sel == SEL_ENB) enb_q <= d_wdata;
      if (dp_sel == SEL_DAT) dat_q <= d_wdata;
      if (dp_sel == SEL_TOG) dat_q <= dat_q ^ d_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  assign pin_oe  = enb_q & dir_q;
  assign pin_out = dat_q & pin_oe;
  assign dat_rd  = (enb_q & ~dir_q & s2_q) | (~(enb_q & ~dir_q) & dat_q);

  always_comb begin
    d_rdata = '0;
    if (rd)
      case (dp_sel)
        SEL_DIR: d_rdata = dir_q;
        SEL_DAT: d_rdata = dat_rd;
        SEL_ENB: d_rdata = enb_q;
        default: d_rdata = '0;
      endcase
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '0 && enb_q == '0 && dat_q == '0));
  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dp_sel == SEL_TOG) |=> (dat_q == ($past(dat_q) ^ $past(d_wdata))));
  // R5
  toggle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && dp_sel == SEL_TOG) |-> (d_rdata == '0));
  // R6
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dp_sel != SEL_DIR && dp_sel != SEL_DAT && dp_sel != SEL_ENB && dp_sel != SEL_TOG)
    |=> ($stable(dir_q) && $stable(enb_q) && $stable(dat_q)));
  // R3
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(pin_oe) && $stable(pin_out)));
  // R9
  dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dp_sel == SEL_DIR) |=> (dir_q == $past(d_wdata)));
endmodule

// File: tb/fgpio_port_tb.sv
module fgpio_port_tb;
  localparam int TCLK = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        a_vld = 1'b0, a_wr = 1'b0;
  logic [3:0]  a_adr = '0;
  logic [15:0] d_wdata = '0, pin_in = '0;
  logic [15:0] d_rdata, pin_out, pin_oe;

  int total = 0, bad = 0;
  logic [15:0] m_dir = '0, m_dat = '0, m_enb = '0;

  fgpio_port u_dut (.clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_wr(a_wr), .a_adr(a_adr),
    .d_wdata(d_wdata), .d_rdata(d_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #(TCLK/2) clk = ~clk;

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    logic [15:0] inp;
    inp = m_enb & ~m_dir;
    case (a[3:1])
      3'd0: return m_dir;
      3'd1: return (inp & pin_in) | (~inp & m_dat);
      3'd2: return m_enb;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, pin_oe, m_enb & m_dir);
    chk(req, pin_out, m_dat & m_enb & m_dir);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    a_vld = 1'b1; a_wr = 1'b1; a_adr = a;
    @(negedge clk);
    a_vld = 1'b0; a_wr = 1'b0; d_wdata = d;
    @(negedge clk);
    case (a[3:1])
      3'd0: m_dir = d;
      3'd1: m_dat = d;
      3'd2: m_enb = d;
      3'd7: m_dat = m_dat ^ d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    a_vld = 1'b1; a_wr = 1'b0; a_adr = a;
    @(negedge clk);
    d = d_rdata;
    a_vld = 1'b0;
  endtask

  initial begin
    #(TCLK * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_pins("R1");
    for (int a = 0; a < 16; a += 2) begin
      bus_rd(a[3:0], r); chk("R1", r, 16'h0);
    end
    // R2 direction and enable store/readback
    bus_wr(4'h0, 16'hA5F0); bus_rd(4'h0, r); chk("R2", r, 16'hA5F0);
    bus_wr(4'h4, 16'hFF0F); bus_rd(4'h4, r); chk("R2", r, 16'hFF0F);
    // R9 write visible right after its data cycle; R3 pin drive
    bus_wr(4'h2, 16'h1234); chk_pins("R9");
    chk_pins("R3");
    // R4 toggle inverts only 1 bits
    bus_wr(4'hE, 16'h00FF); chk_pins("R4");
    bus_wr(4'h0, 16'hFFFF); chk_pins("R4");
    bus_rd(4'h2, r); chk("R4", r, 16'h12CB & 16'hFFFF);
    bus_wr(4'hE, 16'h0000); bus_rd(4'h2, r); chk("R4", r, 16'h12CB);
    // R5 toggle reads zero
    bus_rd(4'hE, r); chk("R5", r, 16'h0);
    // R6 undefined offset write ignored
    bus_wr(4'h6, 16'hFFFF); bus_wr(4'hA, 16'h0000); bus_wr(4'hC, 16'h5555);
    chk_pins("R6");
    bus_rd(4'h0, r); chk("R6", r, 16'hFFFF);
    bus_rd(4'h2, r); chk("R6", r, 16'h12CB);
    bus_rd(4'h4, r); chk("R6", r, 16'hFF0F);
    bus_rd(4'h8, r); chk("R6", r, 16'h0);
    // R8 two-edge synchroniser latency
    bus_wr(4'h0, 16'h0000); bus_wr(4'h4, 16'h0001); bus_wr(4'h2, 16'h0000);
    pin_in = 16'h0001;
    bus_rd(4'h2, r); chk("R8", r, 16'h0000);
    bus_rd(4'h2, r); chk("R8", r, 16'h0001);
    // R7 mixed pins: enabled inputs read pin, others read latch
    bus_wr(4'h4, 16'h00FF); bus_wr(4'h0, 16'h0F0F); bus_wr(4'h2, 16'hAAAA);
    pin_in = 16'h3C3C;
    repeat (2) @(negedge clk);
    bus_rd(4'h2, r); chk("R7", r, exp_rd(4'h2));
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [3:0] a;
      op = $urandom_range(0, 9);
      a = 4'($urandom_range(0, 15));
      if (op < 5) begin
        bus_wr(a, 16'($urandom));
        chk_pins(a[3:1] == 3'd7 ? "R4" : (a[3:1] > 3'd2 ? "R6" : "R3"));
      end else if (op < 9) begin
        bus_rd(a, r);
        chk(a[3:1] == 3'd1 ? "R7" : (a[3:1] == 3'd7 ? "R5" : "R2"), r, exp_rd(a));
      end else begin
        pin_in = 16'($urandom);
        repeat (2) @(negedge clk);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule